// File: doc/BRIEF.md
# Two-Wire Serial Bus Receiver

This block is the receive front end of a two-wire serial bus port. It runs on a fast system clock and oversamples the open-drain clock line (SCL) and data line (SDA). Each line passes through a two-flop synchronizer and a majority filter. The filtered lines are compared with their values one system clock earlier, which gives clock edges and data changes while the clock is high. From these the block recognises start and stop conditions and shifts in data bytes, most significant bit first.

After each byte the block opens an acknowledge slot. During that slot it can pull SDA low through an open-drain enable. The block treats any SDA change while SCL is high in the middle of a byte or acknowledge slot as a protocol violation. In that case it reports a bus error, releases SDA and returns to idle. When the system is in a reduced-power state, a start condition also raises a wake-up request.

A host uses the one-cycle strobes to collect bytes and frame boundaries. It does not need to follow the bus bit by bit.

Top module: `tw_receiver`

## Requirements
- R1: After reset the receiver is idle, `sda_pull_low` is 0, `rx_data` is 0 and every strobe (`rx_valid`, `start_seen`, `stop_seen`, `bus_err`, `wake_req`) is 0.
- R2: An SDA fall while SCL is high produces a one-cycle `start_seen` pulse, enters a transaction and clears the bit count. This applies when the receiver is idle, or when fewer than two bits of the current byte have been sampled outside an acknowledge slot. This second case is a repeated start.
- R3: An SDA rise while SCL is high, under the same conditions as R2, produces a one-cycle `stop_seen` pulse and returns the receiver to idle.
- R4: Data is sampled on SCL rising edges, most significant bit first, so the first bit received lands in `rx_data[7]`. On the rising edge that samples the eighth bit, `rx_valid` pulses for exactly one clock and `rx_data` holds the byte.
- R5: If `ack_en` is 1 at the SCL falling edge that follows the eighth bit, `sda_pull_low` is 1 from that edge until the next SCL falling edge. If `ack_en` is 0, `sda_pull_low` stays 0.
- R6: Inside a transaction, an SDA change while SCL is high raises a one-cycle `bus_err` pulse, releases SDA and returns the receiver to idle, with no `rx_valid` for the broken byte. This applies once two or more bits of the byte have been sampled, or during the acknowledge slot.
- R7: A start condition while `low_power` is 1 raises `wake_req` in the same cycle as `start_seen`. With `low_power` at 0 no `wake_req` is raised.
- R8: While the receiver is idle, SCL pulses shift in nothing and produce no `rx_valid`.
- R9: A one-clock low pulse on SDA while SCL is high is removed by the majority filter and produces no start.
- R10: Several bytes in one transaction are each delivered with their own `rx_valid` pulse, separated by acknowledge slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line level |
| sda_in | input | 1 | Raw serial data line level |
| ack_en | input | 1 | Acknowledge received bytes when 1 |
| low_power | input | 1 | System is in reduced-power mode |
| rx_data | output | 8 | Last complete byte, first bit in bit 7 |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` updated |
| start_seen | output | 1 | One-cycle strobe: start or repeated start |
| stop_seen | output | 1 | One-cycle strobe: stop condition |
| bus_err | output | 1 | One-cycle strobe: illegal SDA change, transfer aborted |
| wake_req | output | 1 | One-cycle wake-up request on start in low-power mode |
| sda_pull_low | output | 1 | Open-drain enable: drive SDA low when 1 |

## Verification
The start strobe and the wake-up request are meant to fall in the same system clock. The bench provokes this by holding `low_power` high while it issues a start condition. Its monitor counts the cycles in which both strobes are high together and compares that count with the number of start pulses. A second start with `low_power` low must add a start pulse and leave the wake-up count unchanged.

// File: rtl/tw_rx_pkg.sv
// Package: shared types for the two-wire receiver.
// Assumes: all consumers run on the same system clock.
package tw_rx_pkg;
    // Line events derived from the filtered SCL/SDA pair.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda_fall_hi;   // SDA fell while SCL stayed high
        logic sda_rise_hi;   // SDA rose while SCL stayed high
        logic sda;           // current filtered SDA level
    } line_ev_t;
endpackage

// File: rtl/tw_line_filter.sv
// Module: tw_line_filter
// Synchronizes one raw bus line and removes short pulses with a majority
// vote over the last WIN synchronized samples.
// Assumes: the idle bus level is high, so every stage resets to 1.
module tw_line_filter #(
    parameter int SYNC = 2,
    parameter int WIN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int HALF = WIN / 2;

    logic [SYNC-1:0] sync_q;
    logic [WIN-1:0]  win_q;
    logic            vote;

    // Synchronizer chain and sample window shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], raw};
            win_q  <= {win_q[WIN-2:0], sync_q[SYNC-1]};
        end
    end

    // Majority vote over the window.
    always_comb begin
        int ones;
        ones = 0;
        for (int i = 0; i < WIN; i++) ones += int'(win_q[i]);
        vote = (ones > HALF);
    end

    // Registered filter output.
    always_ff @(posedge clk) begin
        if (!rst_n) clean <= 1'b1;
        else        clean <= vote;
    end
endmodule

// File: rtl/tw_cond_detect.sv
// Module: tw_cond_detect
// Compares the filtered lines with their previous values and reports
// SCL edges and SDA changes that occur while SCL is high.
// Assumes: inputs are already synchronized and filtered.
module tw_cond_detect
    import tw_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl,
    input  logic     sda,
    output line_ev_t ev
);
    logic scl_q, sda_q;

    // Previous-sample registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Event decode.
    always_comb begin
        ev.scl_rise    = scl & ~scl_q;
        ev.scl_fall    = ~scl & scl_q;
        ev.sda_fall_hi = scl & scl_q & sda_q & ~sda;
        ev.sda_rise_hi = scl & scl_q & ~sda_q & sda;
        ev.sda         = sda;
    end
endmodule

// File: rtl/tw_byte_engine.sv
// Module: tw_byte_engine
// Transaction tracker: classifies SDA changes under SCL high as start,
// stop or error, shifts bits in MSB first and drives the acknowledge slot.
// Assumes: one event record per clock from tw_cond_detect.
module tw_byte_engine
    import tw_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_ev_t          ev,
    input  logic              ack_en,
    input  logic              low_power,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              bus_err,
    output logic              wake_req,
    output logic              sda_pull_low
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] SAFE = CNT_W'(2);

    logic              in_xfer;
    logic              ack_phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              sda_hi_chg;
    logic              mid_byte;

    // A change under SCL high is illegal once the byte is under way.
    always_comb begin
        sda_hi_chg = ev.sda_fall_hi | ev.sda_rise_hi;
        mid_byte   = in_xfer & (ack_phase | (bit_cnt >= SAFE));
    end

    // Transaction state, shifter, strobes and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_xfer      <= 1'b0;
            ack_phase    <= 1'b0;
            bit_cnt      <= '0;
            shreg        <= '0;
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            start_seen   <= 1'b0;
            stop_seen    <= 1'b0;
            bus_err      <= 1'b0;
            wake_req     <= 1'b0;
            sda_pull_low <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
            bus_err    <= 1'b0;
            wake_req   <= 1'b0;
            if (sda_hi_chg) begin
                bit_cnt      <= '0;
                ack_phase    <= 1'b0;
                sda_pull_low <= 1'b0;
                if (mid_byte) begin
                    bus_err <= 1'b1;
                    in_xfer <= 1'b0;
                end else if (ev.sda_fall_hi) begin
                    start_seen <= 1'b1;
                    wake_req   <= low_power;
                    in_xfer    <= 1'b1;
                end else begin
                    stop_seen <= 1'b1;
                    in_xfer   <= 1'b0;
                end
            end else if (in_xfer) begin
                if (ev.scl_rise && !ack_phase && bit_cnt < FULL) begin
                    shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST) begin
                        rx_data  <= {shreg[BYTE_W-2:0], ev.sda};
                        rx_valid <= 1'b1;
                    end
                end
                if (ev.scl_fall) begin
                    if (ack_phase) begin
                        ack_phase    <= 1'b0;
                        bit_cnt      <= '0;
                        sda_pull_low <= 1'b0;
                    end else if (bit_cnt == FULL) begin
                        ack_phase    <= 1'b1;
                        sda_pull_low <= ack_en;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tw_receiver.sv
// Module: tw_receiver (top)
// Two-wire serial bus receive front end: filters both lines, detects
// bus conditions and assembles bytes with an optional acknowledge.
// Assumes: clk is many times faster than SCL; SDA is open drain, so the
// outside world ANDs sda_pull_low (inverted) onto the line.
module tw_receiver #(
    parameter int BYTE_W = 8,
    parameter int SYNC   = 2,
    parameter int WIN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              ack_en,
    input  logic              low_power,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              start_seen,
    output logic              stop_seen,
    output logic              bus_err,
    output logic              wake_req,
    output logic              sda_pull_low
);
    import tw_rx_pkg::*;

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    line_ev_t          ev;

    assign raw_lines = {sda_in, scl_in};

    // One identical filter per bus line keeps their relative timing.
    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        tw_line_filter #(.SYNC(SYNC), .WIN(WIN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    tw_cond_detect u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .scl   (clean_lines[0]),
        .sda   (clean_lines[1]),
        .ev    (ev)
    );

    tw_byte_engine #(.BYTE_W(BYTE_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .ack_en       (ack_en),
        .low_power    (low_power),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .start_seen   (start_seen),
        .stop_seen    (stop_seen),
        .bus_err      (bus_err),
        .wake_req     (wake_req),
        .sda_pull_low (sda_pull_low)
    );
endmodule

// File: rtl/tw_receiver_chk.sv
// Module: tw_receiver_chk
// Protocol checker attached to tw_receiver through bind.
// Assumes: SCL phases last several system clocks.
module tw_receiver_chk (
    input logic clk,
    input logic rst_n,
    input logic ack_en,
    input logic rx_valid,
    input logic start_seen,
    input logic stop_seen,
    input logic bus_err,
    input logic wake_req,
    input logic sda_pull_low
);
    // R7: wake-up only ever accompanies a start.
    a_r7_wake_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> start_seen);

    // R4: byte strobe is a single-cycle pulse.
    a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2: a start is never also an error or a stop.
    a_r2_start_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |-> !bus_err && !stop_seen);

    // R5: pull-low only begins when acknowledge was enabled.
    a_r5_pull_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> $past(ack_en));

    // R6: after an abort SDA stays released.
    a_r6_err_releases: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !sda_pull_low);

    // R3: a stop leaves SDA released.
    a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |-> !sda_pull_low);
endmodule

bind tw_receiver tw_receiver_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_en       (ack_en),
    .rx_valid     (rx_valid),
    .start_seen   (start_seen),
    .stop_seen    (stop_seen),
    .bus_err      (bus_err),
    .wake_req     (wake_req),
    .sda_pull_low (sda_pull_low)
);

// File: tb/sim_tw_receiver.sv
// Directed bench for tw_receiver: one task per scenario, each checking
// its own results through pulse counters kept from the outputs.
module sim_tw_receiver;
    localparam int Q = 20;   // system clocks per quarter SCL period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       ack_en = 1'b0;
    logic       low_power = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, start_seen, stop_seen, bus_err, wake_req, sda_pull_low;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int n_valid = 0, n_start = 0, n_stop = 0, n_err = 0, n_wake = 0, n_both = 0;
    logic [7:0] last_byte = 8'h00;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_bus = sda_m & ~sda_pull_low;   // open-drain wired AND

    tw_receiver u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .ack_en(ack_en), .low_power(low_power), .rx_data(rx_data),
        .rx_valid(rx_valid), .start_seen(start_seen), .stop_seen(stop_seen),
        .bus_err(bus_err), .wake_req(wake_req), .sda_pull_low(sda_pull_low)
    );

    // Pulse counters sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin n_valid++; last_byte = rx_data; end
            if (start_seen) n_start++;
            if (stop_seen) n_stop++;
            if (bus_err) n_err++;
            if (wake_req) n_wake++;
            if (wake_req && start_seen) n_both++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wclk(Q); scl_m = 1'b1; wclk(2 * Q); scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // Acknowledge slot with the master releasing SDA; checks the pull.
    task automatic ack_slot(input logic exp_pull, input string tag);
        sda_m = 1'b1; wclk(Q);
        chk({tag, " pull during ack"}, int'(sda_pull_low), int'(exp_pull));
        scl_m = 1'b1; wclk(2 * Q); scl_m = 1'b0; wclk(Q);
        chk({tag, " pull released after ack"}, int'(sda_pull_low), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wclk(5); rst_n = 1'b1; wclk(2);
        chk("R1 pull", int'(sda_pull_low), 0);
        chk("R1 data", int'(rx_data), 0);
        chk("R1 strobes", int'({rx_valid, start_seen, stop_seen, bus_err, wake_req}), 0);
    endtask

    task automatic t_single_byte();
        int s0 = n_start, p0 = n_stop, v0 = n_valid;
        ack_en = 1'b1;
        do_start();
        chk("R2 start pulse", n_start - s0, 1);
        send_byte(8'hA5);
        chk("R4 one strobe", n_valid - v0, 1);
        chk("R4 byte msb first", int'(last_byte), 'hA5);
        ack_slot(1'b1, "R5");
        do_stop();
        chk("R3 stop pulse", n_stop - p0, 1);
    endtask

    task automatic t_two_bytes_rstart();
        int s0 = n_start, v0 = n_valid, e0 = n_err;
        ack_en = 1'b1;
        do_start();
        send_byte(8'h3C); ack_slot(1'b1, "R10 b0");
        chk("R10 first byte", int'(last_byte), 'h3C);
        send_byte(8'hC1); ack_slot(1'b1, "R10 b1");
        chk("R10 second byte", int'(last_byte), 'hC1);
        do_start();   // repeated start after the acknowledge
        chk("R2 repeated start", n_start - s0, 2);
        send_byte(8'h5A); ack_slot(1'b1, "R2 after rstart");
        chk("R2 byte after rstart", int'(last_byte), 'h5A);
        chk("R10 strobe count", n_valid - v0, 3);
        chk("R2 no error", n_err - e0, 0);
        do_stop();
    endtask

    task automatic t_no_ack();
        ack_en = 1'b0;
        do_start(); send_byte(8'h81);
        chk("R4 byte 81", int'(last_byte), 'h81);
        ack_slot(1'b0, "R5 ack disabled");
        do_stop();
        ack_en = 1'b1;
    endtask

    task automatic t_error_data();
        int e0 = n_err, v0, p0;
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);                 // change under SCL high, bit 4
        scl_m = 1'b0; wclk(Q);
        chk("R6 error pulse", n_err - e0, 1);
        v0 = n_valid; p0 = n_stop;
        send_byte(8'hFF);                      // idle: clocks shift nothing
        chk("R8 no byte while idle", n_valid - v0, 0);
        chk("R6 pull released", int'(sda_pull_low), 0);
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        chk("R6 no stop after error", n_stop - p0, 0);
    endtask

    task automatic t_error_ack();
        int e0 = n_err, v0 = n_valid;
        ack_en = 1'b0;
        do_start(); send_byte(8'h66);
        chk("R4 byte 66", n_valid - v0, 1);
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);                 // change inside ack slot
        scl_m = 1'b0; wclk(Q);
        chk("R6 error in ack slot", n_err - e0, 1);
        scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
        ack_en = 1'b1;
    endtask

    task automatic t_wake();
        int w0 = n_wake, b0 = n_both, s0 = n_start;
        low_power = 1'b1;
        do_start();
        low_power = 1'b0;
        chk("R7 wake raised", n_wake - w0, 1);
        chk("R7 wake same cycle as start", n_both - b0, 1);
        do_stop();
        do_start();
        chk("R7 no wake when awake", n_wake - w0, 1);
        chk("R7 start count", n_start - s0, 2);
        do_stop();
    endtask

    task automatic t_glitch();
        int s0 = n_start;
        scl_m = 1'b1; sda_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(1); sda_m = 1'b1;   // one-clock SDA pulse
        wclk(Q);
        chk("R9 glitch ignored", n_start - s0, 0);
    endtask

    initial begin
        wclk(200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_single_byte();
        t_two_bytes_rstart();
        t_no_ack();
        t_error_data();
        t_error_ack();
        t_wake();
        t_glitch();
        wclk(10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule